// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block is the address-decoding glue for an 8-bit processor with a 16-bit address bus. On every bus cycle it looks at the CPU address and activates exactly one active-low chip select. The possible targets are the low RAM, an I/O page, one of four SRAM chips behind a banked high-RAM window, or a banked ROM. For the two banked windows it also forms a wider physical address. The low CPU address bits pass through unchanged, and a bank latch supplies the bits above them.

The two bank latches sit in zero page. They snoop CPU writes and cannot be read back. A write to address $0000 loads the RAM bank, and a write to $0001 loads the ROM bank. Both writes still go into low RAM as usual.

The top three bits of the ROM latch are hide flags. Each flag removes one window from the map, so that the low RAM underneath answers reads and writes in that range. The top 8 KiB of ROM cannot be hidden, so the interrupt vectors always stay reachable.

Top module: `bank_addr_decoder`

## Requirements
- R1: Exactly one of the seven chip selects is low in every cycle. Low RAM (`lowram_cs_n`) is selected for every address that no enabled window claims, which includes all of $0000-$9EFF.
- R2: With the I/O hide flag clear, addresses $9F00-$9FFF drive `io_cs_n` low.
- R3: With the high-RAM hide flag clear, addresses $A000-$BFFF select high RAM. The chip is chosen by RAM-bank bits [7:6]: value n drives `hiram_cs_n[n]` low.
- R4: While high RAM is selected, `hiram_addr` equals {RAM-bank bits [5:0], CPU address bits [12:0]}.
- R5: Addresses $C000-$FFFF select ROM when not hidden. `rom_addr` equals {ROM-bank bits [4:0], CPU address bits [13:0]}.
- R6: A CPU write to $0000 loads the write data into the RAM bank at the clock edge that ends the cycle. The new value applies from the next cycle. During the write cycle itself, low RAM is selected.
- R7: A CPU write to $0001 loads the ROM-bank latch in the same way as R6, and low RAM is selected during that write.
- R8: ROM-latch bit 5 hides the I/O page, bit 6 hides the high-RAM window, and bit 7 hides $C000-$DFFF. A hidden range selects low RAM instead.
- R9: Addresses $E000-$FFFF select ROM whatever the hide flags hold.
- R10: Synchronous active-high reset clears both latches. This gives RAM bank 0, ROM bank 0 and all windows visible.
- R11: Writes to any address other than $0000 and $0001, and reads of any address, leave both latches unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; a cycle ends on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | High during a CPU write cycle |
| lowram_cs_n | output | 1 | Low-RAM select, active low |
| io_cs_n | output | 1 | I/O page select, active low |
| hiram_cs_n | output | 4 | Per-chip high-RAM selects, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| hiram_addr | output | 19 | Physical address for the high-RAM chips |
| rom_addr | output | 19 | Physical address for the ROM |

## Verification
The assertions assume that the address, data and write-enable inputs hold steady across the rising clock edge and change only between edges. They also assume that reset is held from time zero, so the latches start defined. The bench drives every input on the falling edge and samples the selects two nanoseconds later. Each write is completed by a single rising edge before the next vector is applied, so a latch update is seen only by the cycle that follows it.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
  localparam int CPU_AW = 16;
  localparam logic [CPU_AW-1:0] RAM_BANK_LOC = 16'h0000;
  localparam logic [CPU_AW-1:0] ROM_BANK_LOC = 16'h0001;
  localparam int HIDE_W   = 3;
  localparam int HIDE_IO  = 0;
  localparam int HIDE_HI  = 1;
  localparam int HIDE_RLO = 2;

  typedef enum logic [1:0] {
    RGN_LOW,
    RGN_IO,
    RGN_HIRAM,
    RGN_ROM
  } region_e;
endpackage

// File: rtl/bdec_bank_regs.sv
module bdec_bank_regs
  import bdec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] ram_bank,
  output logic [DATA_W-1:0] rom_bank
);
  logic hit_ram, hit_rom;

  assign hit_ram = we && (addr == RAM_BANK_LOC);
  assign hit_rom = we && (addr == ROM_BANK_LOC);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_bank <= '0;
      rom_bank <= '0;
    end else begin
      if (hit_ram) ram_bank <= wdata;
      if (hit_rom) rom_bank <= wdata;
    end
  end

  assert_ram_load_R6: assert property (@(posedge clk) disable iff (rst)
    (we && addr == RAM_BANK_LOC) |=> (ram_bank == $past(wdata)));

  assert_rom_load_R7: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ROM_BANK_LOC) |=> (rom_bank == $past(wdata)));

  assert_other_keep_R11: assert property (@(posedge clk) disable iff (rst)
    (!we || addr > ROM_BANK_LOC) |=> ($stable(ram_bank) && $stable(rom_bank)));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (ram_bank == '0 && rom_bank == '0));
endmodule

// File: rtl/bdec_region.sv
module bdec_region
  import bdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        addr_hi,
  input  logic [HIDE_W-1:0] hide,
  output region_e           region
);
  logic       upper;
  logic [1:0] quarter;
  logic       io_page;

  assign upper   = addr_hi[7];
  assign quarter = addr_hi[6:5];
  assign io_page = &addr_hi[4:0];

  always_comb begin
    region = RGN_LOW;
    if (upper) begin
      unique case (quarter)
        2'b00:   if (io_page && !hide[HIDE_IO]) region = RGN_IO;
        2'b01:   if (!hide[HIDE_HI])            region = RGN_HIRAM;
        2'b10:   if (!hide[HIDE_RLO])           region = RGN_ROM;
        default:                                region = RGN_ROM;
      endcase
    end
  end

  assert_vectors_rom_R9: assert property (@(posedge clk) disable iff (rst)
    (addr_hi[7:5] == 3'b111) |-> (region == RGN_ROM));

  assert_lower_half_low_R1: assert property (@(posedge clk) disable iff (rst)
    (!addr_hi[7]) |-> (region == RGN_LOW));

  assert_hidden_io_R8: assert property (@(posedge clk) disable iff (rst)
    (hide[HIDE_IO] && addr_hi == 8'h9F) |-> (region == RGN_LOW));
endmodule

// File: rtl/bdec_selects.sv
module bdec_selects
  import bdec_pkg::*;
#(
  parameter int CHIP_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  region_e                   region,
  input  logic [CHIP_W-1:0]         chip,
  output logic                      lowram_cs_n,
  output logic                      io_cs_n,
  output logic [(1<<CHIP_W)-1:0]    hiram_cs_n,
  output logic                      rom_cs_n
);
  localparam int N_CHIPS = 1 << CHIP_W;

  assign lowram_cs_n = (region != RGN_LOW);
  assign io_cs_n     = (region != RGN_IO);
  assign rom_cs_n    = (region != RGN_ROM);

  for (genvar g = 0; g < N_CHIPS; g++) begin : g_chip
    assign hiram_cs_n[g] = !((region == RGN_HIRAM) && (chip == CHIP_W'(g)));
  end

  assert_one_select_R1: assert property (@(posedge clk) disable iff (rst)
    $countones({lowram_cs_n, io_cs_n, hiram_cs_n, rom_cs_n}) == N_CHIPS + 2);

  assert_chip_pick_R3: assert property (@(posedge clk) disable iff (rst)
    (region == RGN_HIRAM) |-> (hiram_cs_n[chip] == 1'b0));
endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
  import bdec_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HI_OFS_W   = 13,
  parameter int ROM_OFS_W  = 14,
  parameter int RAM_PAGE_W = 6,
  parameter int CHIP_W     = 2,
  parameter int ROM_BANK_W = 5
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [15:0]                         cpu_addr,
  input  logic [DATA_W-1:0]                   cpu_wdata,
  input  logic                                cpu_we,
  output logic                                lowram_cs_n,
  output logic                                io_cs_n,
  output logic [(1<<CHIP_W)-1:0]              hiram_cs_n,
  output logic                                rom_cs_n,
  output logic [RAM_PAGE_W+HI_OFS_W-1:0]      hiram_addr,
  output logic [ROM_BANK_W+ROM_OFS_W-1:0]     rom_addr
);
  localparam int HI_ADDR_W  = RAM_PAGE_W + HI_OFS_W;
  localparam int ROM_ADDR_W = ROM_BANK_W + ROM_OFS_W;

  logic [DATA_W-1:0] ram_bank, rom_bank;
  logic [HIDE_W-1:0] hide;
  region_e           region;

  bdec_bank_regs #(.DATA_W(DATA_W)) i_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (cpu_addr),
    .wdata    (cpu_wdata),
    .we       (cpu_we),
    .ram_bank (ram_bank),
    .rom_bank (rom_bank)
  );

  assign hide = rom_bank[DATA_W-1 -: HIDE_W];

  bdec_region i_region (
    .clk     (clk),
    .rst     (rst),
    .addr_hi (cpu_addr[15:8]),
    .hide    (hide),
    .region  (region)
  );

  bdec_selects #(.CHIP_W(CHIP_W)) i_sel (
    .clk         (clk),
    .rst         (rst),
    .region      (region),
    .chip        (ram_bank[DATA_W-1 -: CHIP_W]),
    .lowram_cs_n (lowram_cs_n),
    .io_cs_n     (io_cs_n),
    .hiram_cs_n  (hiram_cs_n),
    .rom_cs_n    (rom_cs_n)
  );

  assign hiram_addr = {ram_bank[RAM_PAGE_W-1:0], cpu_addr[HI_OFS_W-1:0]};
  assign rom_addr   = {rom_bank[ROM_BANK_W-1:0], cpu_addr[ROM_OFS_W-1:0]};

  assert_page_follows_write_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_we && cpu_addr == RAM_BANK_LOC) && !(&hiram_cs_n))
      |-> (hiram_addr[HI_ADDR_W-1 -: RAM_PAGE_W] == $past(cpu_wdata[RAM_PAGE_W-1:0])));

  assert_rom_bank_follows_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_we && cpu_addr == ROM_BANK_LOC) && !rom_cs_n)
      |-> (rom_addr[ROM_ADDR_W-1 -: ROM_BANK_W] == $past(cpu_wdata[ROM_BANK_W-1:0])));

  assert_latch_write_low_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr <= ROM_BANK_LOC) |-> !lowram_cs_n);
endmodule

// File: tb/test_bank_addr_decoder.sv
module test_bank_addr_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic        lowram_cs_n, io_cs_n, rom_cs_n;
  logic [3:0]  hiram_cs_n;
  logic [18:0] hiram_addr, rom_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bank_addr_decoder i_bank_addr_decoder (
    .clk (clk), .rst (rst), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
    .cpu_we (cpu_we), .lowram_cs_n (lowram_cs_n), .io_cs_n (io_cs_n),
    .hiram_cs_n (hiram_cs_n), .rom_cs_n (rom_cs_n),
    .hiram_addr (hiram_addr), .rom_addr (rom_addr)
  );

  // select order {rom, hiram[3:0], io, low}, active low
  localparam logic [6:0] LOW = 7'b1111110;
  localparam logic [6:0] IO  = 7'b1111101;
  localparam logic [6:0] H0  = 7'b1111011;
  localparam logic [6:0] H1  = 7'b1110111;
  localparam logic [6:0] H3  = 7'b1011111;
  localparam logic [6:0] ROM = 7'b0111111;

  localparam int NV = 29;
  // {addr, we, wdata, expected selects, expected physical address}
  localparam logic [50:0] VEC [0:NV-1] = '{
    {16'h1234, 1'b0, 8'h00, LOW, 19'h0},      // R1
    {16'h9F00, 1'b0, 8'h00, IO,  19'h0},      // R2
    {16'h9FFF, 1'b0, 8'h00, IO,  19'h0},      // R2
    {16'h9EFF, 1'b0, 8'h00, LOW, 19'h0},      // R1
    {16'hA000, 1'b0, 8'h00, H0,  19'h00000},  // R3 R4 R10
    {16'hBFFF, 1'b0, 8'h00, H0,  19'h01FFF},  // R4
    {16'hC000, 1'b0, 8'h00, ROM, 19'h00000},  // R5
    {16'hFFFC, 1'b0, 8'h00, ROM, 19'h03FFC},  // R5
    {16'h0000, 1'b1, 8'h47, LOW, 19'h0},      // R6 write
    {16'hA123, 1'b0, 8'h00, H1,  19'h0E123},  // R6 R3 R4
    {16'h0001, 1'b1, 8'h13, LOW, 19'h0},      // R7 write
    {16'hC010, 1'b0, 8'h00, ROM, 19'h4C010},  // R7 R5
    {16'hE000, 1'b0, 8'h00, ROM, 19'h4E000},  // R5
    {16'h0000, 1'b1, 8'hFF, LOW, 19'h0},      // R6
    {16'hBFFF, 1'b0, 8'h00, H3,  19'h7FFFF},  // R3 R4
    {16'h0001, 1'b1, 8'hE2, LOW, 19'h0},      // R8 all hidden
    {16'h9F80, 1'b0, 8'h00, LOW, 19'h0},      // R8
    {16'hA800, 1'b0, 8'h00, LOW, 19'h0},      // R8
    {16'hC000, 1'b0, 8'h00, LOW, 19'h0},      // R8
    {16'hDFFF, 1'b0, 8'h00, LOW, 19'h0},      // R8
    {16'hE000, 1'b0, 8'h00, ROM, 19'h0A000},  // R9
    {16'hFFFF, 1'b0, 8'h00, ROM, 19'h0BFFF},  // R9
    {16'h0001, 1'b1, 8'h40, LOW, 19'h0},      // R8 only high RAM hidden
    {16'h9F10, 1'b0, 8'h00, IO,  19'h0},      // R8
    {16'hB000, 1'b0, 8'h00, LOW, 19'h0},      // R8
    {16'hD000, 1'b0, 8'h00, ROM, 19'h01000},  // R8
    {16'h0002, 1'b1, 8'h55, LOW, 19'h0},      // R11
    {16'h8000, 1'b1, 8'h00, LOW, 19'h0},      // R11
    {16'h0001, 1'b1, 8'h00, LOW, 19'h0}       // R7 clear flags
  };

  function automatic string req_of(input logic [6:0] cs);
    if (cs == ROM) return "R5";
    if (cs == IO)  return "R2";
    if (cs == LOW) return "R1";
    return "R3";
  endfunction

  task automatic check(input string req, input logic [6:0] ecs, input logic [18:0] ea);
    logic [6:0] cs;
    cs = {rom_cs_n, hiram_cs_n, io_cs_n, lowram_cs_n};
    checks++;
    if (cs !== ecs) begin
      errors++;
      $display("FAIL %s addr=%h selects actual=%b expected=%b", req, cpu_addr, cs, ecs);
    end else if (ecs == ROM && rom_addr !== ea) begin
      errors++;
      $display("FAIL %s addr=%h rom_addr actual=%h expected=%h", req, cpu_addr, rom_addr, ea);
    end else if (ecs != ROM && ecs != LOW && ecs != IO && hiram_addr !== ea) begin
      errors++;
      $display("FAIL R4 addr=%h hiram_addr actual=%h expected=%h", cpu_addr, hiram_addr, ea);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_we = w; cpu_wdata = d;
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][50:35], VEC[i][34], VEC[i][33:26]);
      check(req_of(VEC[i][25:19]), VEC[i][25:19], VEC[i][18:0]);
    end
    // R11: banks after stray write still {chip 3, page 63}
    drive(16'hA000, 1'b0, 8'h00);
    check("R11", H3, 19'h7E000);
    // R10: load non-zero banks, then reset
    drive(16'h0001, 1'b1, 8'hE5);
    drive(16'h0000, 1'b1, 8'hC9);
    drive(16'h1000, 1'b0, 8'h00);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    drive(16'h9F00, 1'b0, 8'h00);
    check("R10", IO, 19'h0);
    drive(16'hA000, 1'b0, 8'h00);
    check("R10", H0, 19'h00000);
    drive(16'hC000, 1'b0, 8'h00);
    check("R10", ROM, 19'h00000);
    // R9 with every flag set
    drive(16'h0001, 1'b1, 8'hFF);
    drive(16'hFFFA, 1'b0, 8'h00);
    check("R9", ROM, 19'h7FFFA);
    drive(16'h0000, 1'b0, 8'h00);
    check("R1", LOW, 19'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule